// File: doc/BRIEF.md
# Selectable-Accumulator CPU Sequencer

This block is the control core of a small 16-bit processor. It has two general registers, X and Y, and a selector that marks one of them as the accumulator. The sequencer fetches each instruction from a byte-wide 64 KB memory over a request/ready port. An instruction is a 16-bit opcode word, followed for some opcodes by one 16-bit operand word. The block then carries out the instruction. It owns the program counter, X, Y and an 8-bit status byte. It runs loads, stores, indirect accesses, immediate writes, the register selector, jumps, status clear and halt. Arithmetic and logic opcodes go to an external ALU through a one-cycle combinational port.

The control is a single enumerated state machine with these states:
- `ST_FETCH_HI` and `ST_FETCH_LO` read the two opcode bytes.
- `ST_OPND_HI` and `ST_OPND_LO` read the two operand bytes.
- `ST_EXEC` performs the instruction.
- `ST_MEM_HI` and `ST_MEM_LO` carry the two bytes of a data load or store.
- `ST_HALT` is absorbing.

The transitions are:
- fetch-hi to fetch-lo on ready.
- fetch-lo to operand-hi if the opcode takes an operand, otherwise to exec.
- operand-hi to operand-lo to exec.
- exec to mem-hi for loads and stores.
- exec to halt for HLT.
- exec to fetch-hi for everything else.
- mem-hi to mem-lo to fetch-hi.

Top module: `acc_cpu_seq`

## Requirements
- R1: After reset the PC is 0x1000, X, Y and every status bit are zero, `halted` is low, and the first request reads address 0x1000.
- R2: Opcodes are 16-bit words stored high byte first. The opcodes are NOP 0x0000, LFM 0x0001, WTM 0x0002, SRA 0x0003, AXY 0x0004, EQU 0x0008, JPZ 0x000A, JNZ 0x000B, JMP 0x000C, CLR 0x000D, HLT 0x000E, DWR 0x0014, ILM 0x0015 and IWR 0x0016. Only LFM, WTM, SRA, JPZ, JNZ, JMP and DWR are followed by an operand word.
- R3: A memory request keeps its address, write flag and write data stable until `mem_ready` is high; each ready transfers one byte.
- R4: LFM loads the accumulator from the operand address, and WTM stores the accumulator there. Both are big-endian: the high byte is at A and the low byte at A+1.
- R5: DWR writes the operand word to the accumulator. SRA selects Y when operand bit 0 is 1 and X when it is 0.
- R6: ILM loads the accumulator from the address held in the accumulator. IWR stores the accumulator to the address held in the other register.
- R7: JMP always loads the operand into the PC. JPZ jumps when the accumulator is zero, and JNZ jumps when it is non-zero. A jump not taken continues after the operand word.
- R8: A store byte whose address is 0x0FFF or below issues no memory request. A store straddling 0x0FFF/0x1000 writes only its low byte.
- R9: HLT sets status bit 3. Once the instruction ends, `halted` stays high and no request is issued until reset.
- R10: CLR zeroes the status byte, so X becomes the accumulator again. The status byte layout is: bit 0 equality, bit 1 accumulator select, bit 2 divide error, bit 3 halt, bits 7:4 zero.
- R11: Opcodes whose top two bits are 11, and every undefined opcode, behave as NOP.
- R12: For ALU opcodes, `alu_go` pulses for one cycle with no memory request pending. The result goes to the accumulator, except that compares (0x0008, 0x0009) write `alu_eq` to the equality bit. Divide (0x0007) also writes `alu_dz` to the divide-error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req | output | 1 | Memory byte request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with ready |
| mem_ready | input | 1 | Request completes this cycle |
| alu_go | output | 1 | ALU opcode executes this cycle |
| alu_op | output | 16 | Current opcode word |
| alu_x | output | 16 | Register X |
| alu_y | output | 16 | Register Y |
| alu_act | output | 1 | Accumulator select (1 = Y) |
| alu_res | input | 16 | ALU result |
| alu_eq | input | 1 | Compare outcome |
| alu_dz | input | 1 | Divide-by-zero flag |
| cpu_status | output | 8 | Status byte |
| halted | output | 1 | Processor has stopped |

## Verification
The bench builds the block with its default reset PC 0x1000 and ROM limit 0x0FFF. The bench's own memory latency is swept from zero to three wait cycles. This makes every handshake state stall and resume, and puts the ROM/RAM boundary byte inside reach of a straddling store. Immediate and load values are swept across patterns that include zero, all ones and single-bit values. These patterns drive both jump outcomes and both compare outcomes.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam logic [15:0] OP_NOP = 16'h0000;
    localparam logic [15:0] OP_LFM = 16'h0001;
    localparam logic [15:0] OP_WTM = 16'h0002;
    localparam logic [15:0] OP_SRA = 16'h0003;
    localparam logic [15:0] OP_AXY = 16'h0004;
    localparam logic [15:0] OP_SXY = 16'h0005;
    localparam logic [15:0] OP_MXY = 16'h0006;
    localparam logic [15:0] OP_DXY = 16'h0007;
    localparam logic [15:0] OP_EQU = 16'h0008;
    localparam logic [15:0] OP_LEQ = 16'h0009;
    localparam logic [15:0] OP_JPZ = 16'h000A;
    localparam logic [15:0] OP_JNZ = 16'h000B;
    localparam logic [15:0] OP_JMP = 16'h000C;
    localparam logic [15:0] OP_CLR = 16'h000D;
    localparam logic [15:0] OP_HLT = 16'h000E;
    localparam logic [15:0] OP_BSL = 16'h000F;
    localparam logic [15:0] OP_BSR = 16'h0010;
    localparam logic [15:0] OP_AND = 16'h0011;
    localparam logic [15:0] OP_ORA = 16'h0012;
    localparam logic [15:0] OP_XOR = 16'h0013;
    localparam logic [15:0] OP_DWR = 16'h0014;
    localparam logic [15:0] OP_ILM = 16'h0015;
    localparam logic [15:0] OP_IWR = 16'h0016;
    localparam logic [15:0] OP_INC = 16'h0017;
    localparam logic [15:0] OP_DEC = 16'h0018;

    typedef enum logic [3:0] {
        C_NOP, C_LFM, C_WTM, C_SRA, C_JPZ, C_JNZ, C_JMP,
        C_CLR, C_HLT, C_DWR, C_ILM, C_IWR, C_ALU
    } op_class_e;

    typedef enum logic [2:0] {
        ST_FETCH_HI, ST_FETCH_LO, ST_OPND_HI, ST_OPND_LO,
        ST_EXEC, ST_MEM_HI, ST_MEM_LO, ST_HALT
    } seq_state_e;

endpackage

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
    import acc_cpu_pkg::*;
(
    input  logic [15:0] op_word,
    output op_class_e   cls,
    output logic        need_opnd,
    output logic        is_cmp,
    output logic        is_div
);

    always_comb begin
        cls       = C_NOP;
        need_opnd = 1'b0;
        is_cmp    = 1'b0;
        is_div    = 1'b0;
        unique case (op_word)
            OP_LFM: begin cls = C_LFM; need_opnd = 1'b1; end
            OP_WTM: begin cls = C_WTM; need_opnd = 1'b1; end
            OP_SRA: begin cls = C_SRA; need_opnd = 1'b1; end
            OP_JPZ: begin cls = C_JPZ; need_opnd = 1'b1; end
            OP_JNZ: begin cls = C_JNZ; need_opnd = 1'b1; end
            OP_JMP: begin cls = C_JMP; need_opnd = 1'b1; end
            OP_DWR: begin cls = C_DWR; need_opnd = 1'b1; end
            OP_CLR: cls = C_CLR;
            OP_HLT: cls = C_HLT;
            OP_ILM: cls = C_ILM;
            OP_IWR: cls = C_IWR;
            OP_AXY, OP_SXY, OP_MXY, OP_BSL, OP_BSR,
            OP_AND, OP_ORA, OP_XOR, OP_INC, OP_DEC: cls = C_ALU;
            OP_DXY: begin cls = C_ALU; is_div = 1'b1; end
            OP_EQU, OP_LEQ: begin cls = C_ALU; is_cmp = 1'b1; end
            default: cls = C_NOP;
        endcase
    end

endmodule

// File: rtl/acc_cpu_regs.sv
module acc_cpu_regs (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        acc_we,
    input  logic [15:0] acc_wd,
    input  logic        act_we,
    input  logic        act_wd,
    input  logic        eq_we,
    input  logic        eq_wd,
    input  logic        dz_we,
    input  logic        dz_wd,
    input  logic        halt_set,
    output logic [15:0] x_q,
    output logic [15:0] y_q,
    output logic        act_q,
    output logic [7:0]  status_q
);

    logic eq_q, dz_q, halt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q    <= '0;
            y_q    <= '0;
            act_q  <= 1'b0;
            eq_q   <= 1'b0;
            dz_q   <= 1'b0;
            halt_q <= 1'b0;
        end else begin
            if (acc_we) begin
                if (act_q) y_q <= acc_wd;
                else       x_q <= acc_wd;
            end
            if (clr) begin
                act_q  <= 1'b0;
                eq_q   <= 1'b0;
                dz_q   <= 1'b0;
                halt_q <= 1'b0;
            end else begin
                if (act_we)   act_q  <= act_wd;
                if (eq_we)    eq_q   <= eq_wd;
                if (dz_we)    dz_q   <= dz_wd;
                if (halt_set) halt_q <= 1'b1;
            end
        end
    end

    assign status_q = {4'b0000, halt_q, dz_q, act_q, eq_q};

endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
    import acc_cpu_pkg::*;
#(
    parameter logic [15:0] RESET_PC = 16'h1000,
    parameter logic [15:0] ROM_LAST = 16'h0FFF
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic        mem_req,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata,
    input  logic        mem_ready,
    output logic        alu_go,
    output logic [15:0] alu_op,
    output logic [15:0] alu_x,
    output logic [15:0] alu_y,
    output logic        alu_act,
    input  logic [15:0] alu_res,
    input  logic        alu_eq,
    input  logic        alu_dz,
    output logic [7:0]  cpu_status,
    output logic        halted
);

    localparam logic [15:0] ONE = 16'd1;

    seq_state_e state, state_n;
    logic [15:0] pc, ir, opnd, maddr, mval;
    logic [7:0]  mhi;
    logic        mw;

    logic [15:0] dec_word;
    op_class_e   cls;
    logic        need_opnd, is_cmp, is_div;

    logic [15:0] x_q, y_q, acc, other;
    logic        act_q;

    logic        acc_we, act_we, eq_we, dz_we, clr, halt_set;
    logic [15:0] acc_wd;
    logic        in_exec, in_mem, rom_hit, advance, jump_take;

    assign dec_word = (state == ST_FETCH_LO) ? {ir[15:8], mem_rdata} : ir;

    acc_cpu_decode u_dec (
        .op_word   (dec_word),
        .cls       (cls),
        .need_opnd (need_opnd),
        .is_cmp    (is_cmp),
        .is_div    (is_div)
    );

    acc_cpu_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .acc_we   (acc_we),
        .acc_wd   (acc_wd),
        .act_we   (act_we),
        .act_wd   (opnd[0]),
        .eq_we    (eq_we),
        .eq_wd    (alu_eq),
        .dz_we    (dz_we),
        .dz_wd    (alu_dz),
        .halt_set (halt_set),
        .x_q      (x_q),
        .y_q      (y_q),
        .act_q    (act_q),
        .status_q (cpu_status)
    );

    assign acc     = act_q ? y_q : x_q;
    assign other   = act_q ? x_q : y_q;
    assign in_exec = (state == ST_EXEC);
    assign in_mem  = (state == ST_MEM_HI) || (state == ST_MEM_LO);

    // ---------------- output process ----------------
    always_comb begin
        mem_addr  = pc;
        mem_wdata = 8'h00;
        unique case (state)
            ST_MEM_HI: begin
                mem_addr  = maddr;
                mem_wdata = mw ? mval[15:8] : 8'h00;
            end
            ST_MEM_LO: begin
                mem_addr  = maddr + ONE;
                mem_wdata = mw ? mval[7:0] : 8'h00;
            end
            default: mem_addr = pc;
        endcase
    end

    assign rom_hit = in_mem && mw && (mem_addr <= ROM_LAST);
    assign mem_req = (state == ST_FETCH_HI) || (state == ST_FETCH_LO) ||
                     (state == ST_OPND_HI)  || (state == ST_OPND_LO)  ||
                     (in_mem && !rom_hit);
    assign mem_we  = in_mem && mw && !rom_hit;
    assign advance = mem_ready || rom_hit;
    assign halted  = (state == ST_HALT);

    assign alu_go  = in_exec && (cls == C_ALU);
    assign alu_op  = ir;
    assign alu_x   = x_q;
    assign alu_y   = y_q;
    assign alu_act = act_q;

    always_comb begin
        jump_take = 1'b0;
        unique case (cls)
            C_JMP:   jump_take = 1'b1;
            C_JPZ:   jump_take = (acc == 16'h0000);
            C_JNZ:   jump_take = (acc != 16'h0000);
            default: jump_take = 1'b0;
        endcase
    end

    always_comb begin
        acc_we   = 1'b0;
        acc_wd   = alu_res;
        act_we   = in_exec && (cls == C_SRA);
        eq_we    = alu_go && is_cmp;
        dz_we    = alu_go && is_div;
        clr      = in_exec && (cls == C_CLR);
        halt_set = in_exec && (cls == C_HLT);
        if (in_exec && cls == C_DWR) begin
            acc_we = 1'b1;
            acc_wd = opnd;
        end else if (alu_go && !is_cmp) begin
            acc_we = 1'b1;
            acc_wd = alu_res;
        end else if (state == ST_MEM_LO && !mw && mem_ready) begin
            acc_we = 1'b1;
            acc_wd = {mhi, mem_rdata};
        end
    end

    // ---------------- next-state logic ----------------
    always_comb begin
        state_n = state;
        unique case (state)
            ST_FETCH_HI: if (mem_ready) state_n = ST_FETCH_LO;
            ST_FETCH_LO: if (mem_ready) state_n = need_opnd ? ST_OPND_HI : ST_EXEC;
            ST_OPND_HI:  if (mem_ready) state_n = ST_OPND_LO;
            ST_OPND_LO:  if (mem_ready) state_n = ST_EXEC;
            ST_EXEC: begin
                unique case (cls)
                    C_LFM, C_WTM, C_ILM, C_IWR: state_n = ST_MEM_HI;
                    C_HLT:                      state_n = ST_HALT;
                    default:                    state_n = ST_FETCH_HI;
                endcase
            end
            ST_MEM_HI: if (advance) state_n = ST_MEM_LO;
            ST_MEM_LO: if (advance) state_n = ST_FETCH_HI;
            ST_HALT:   state_n = ST_HALT;
            default:   state_n = ST_FETCH_HI;
        endcase
    end

    // ---------------- state register and datapath ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_FETCH_HI;
            pc    <= RESET_PC;
            ir    <= '0;
            opnd  <= '0;
            maddr <= '0;
            mval  <= '0;
            mhi   <= '0;
            mw    <= 1'b0;
        end else begin
            state <= state_n;
            unique case (state)
                ST_FETCH_HI: if (mem_ready) begin ir[15:8] <= mem_rdata; pc <= pc + ONE; end
                ST_FETCH_LO: if (mem_ready) begin ir[7:0]  <= mem_rdata; pc <= pc + ONE; end
                ST_OPND_HI:  if (mem_ready) begin opnd[15:8] <= mem_rdata; pc <= pc + ONE; end
                ST_OPND_LO:  if (mem_ready) begin opnd[7:0]  <= mem_rdata; pc <= pc + ONE; end
                ST_EXEC: begin
                    if (jump_take) pc <= opnd;
                    unique case (cls)
                        C_LFM: begin maddr <= opnd;  mw <= 1'b0; end
                        C_ILM: begin maddr <= acc;   mw <= 1'b0; end
                        C_WTM: begin maddr <= opnd;  mw <= 1'b1; mval <= acc; end
                        C_IWR: begin maddr <= other; mw <= 1'b1; mval <= acc; end
                        default: ;
                    endcase
                end
                ST_MEM_HI: if (advance) mhi <= mem_rdata;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/acc_cpu_seq_chk.sv
module acc_cpu_seq_chk #(
    parameter logic [15:0] ROM_LAST = 16'h0FFF
) (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic        mem_we,
    input logic [15:0] mem_addr,
    input logic [7:0]  mem_wdata,
    input logic        mem_ready,
    input logic        alu_go,
    input logic        halted
);

    // R9
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R9
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_req);

    // R8
    rom_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_addr > ROM_LAST));

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R12
    alu_idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alu_go |-> !mem_req);

    // R12
    alu_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alu_go |=> !alu_go);

endmodule

bind acc_cpu_seq acc_cpu_seq_chk #(.ROM_LAST(ROM_LAST)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready),
    .alu_go    (alu_go),
    .halted    (halted)
);

// File: tb/acc_cpu_seq_tb.sv
module acc_cpu_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_req, mem_we, mem_ready = 1'b0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata = 8'h00;
    logic        alu_go, alu_act;
    logic [15:0] alu_op, alu_x, alu_y, alu_res;
    logic        alu_eq, alu_dz;
    logic [7:0]  cpu_status;
    logic        halted;

    always #4 clk = ~clk;

    acc_cpu_seq u_dut (
        .clk(clk), .rst_n(rst_n),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .alu_go(alu_go), .alu_op(alu_op), .alu_x(alu_x), .alu_y(alu_y),
        .alu_act(alu_act), .alu_res(alu_res), .alu_eq(alu_eq), .alu_dz(alu_dz),
        .cpu_status(cpu_status), .halted(halted)
    );

    // simple ALU model: add, increment, compare
    logic [15:0] m_acc;
    assign m_acc   = alu_act ? alu_y : alu_x;
    assign alu_res = (alu_op == 16'h0004) ? (alu_x + alu_y) :
                     (alu_op == 16'h0017) ? (m_acc + 16'd1) : 16'h0000;
    assign alu_eq  = (alu_x == alu_y);
    assign alu_dz  = 1'b0;

    logic [7:0]  mem [logic [15:0]];
    int          lat = 0;
    int          wcnt = 0;
    int          rom_wr = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    logic [15:0] ptr;

    function automatic logic [7:0] rd(input logic [15:0] a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    function automatic logic [15:0] rdw(input logic [15:0] a);
        return {rd(a), rd(a + 16'd1)};
    endfunction

    always @(negedge clk) begin
        if (!rst_n || !mem_req) begin
            mem_ready = 1'b0;
            wcnt = 0;
        end else if (wcnt >= lat) begin
            mem_ready = 1'b1;
            wcnt = 0;
            if (mem_we) begin
                if (mem_addr <= 16'h0FFF) rom_wr++;
                mem[mem_addr] = mem_wdata;
            end else begin
                mem_rdata = rd(mem_addr);
            end
        end else begin
            mem_ready = 1'b0;
            wcnt++;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic emit(input logic [15:0] w);
        mem[ptr] = w[15:8];
        mem[ptr + 16'd1] = w[7:0];
        ptr = ptr + 16'd2;
    endtask

    task automatic put(input logic [15:0] a, input logic [15:0] w);
        mem[a] = w[15:8];
        mem[a + 16'd1] = w[7:0];
    endtask

    task automatic start_prog();
        mem.delete();
        ptr = 16'h1000;
        rom_wr = 0;
    endtask

    task automatic run();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4000 && !halted; i++) @(negedge clk);
        #1;
        chk(halted, "R9 halt reached", {31'd0, halted}, 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    logic [15:0] vals [4];
    logic [15:0] pa [4];
    logic [15:0] pb [4];

    initial begin
        vals[0] = 16'h0000; vals[1] = 16'hFFFF; vals[2] = 16'h8001; vals[3] = 16'h1234;
        pa[0] = 16'h0005; pa[1] = 16'hFFFF; pa[2] = 16'h7000; pa[3] = 16'h00AA;
        pb[0] = 16'h0000; pb[1] = 16'h0001; pb[2] = 16'h1000; pb[3] = 16'h0055;

        // ---- R1: reset state ----
        start_prog();
        emit(16'h000E);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(mem_req && !mem_we, "R1 first request is read", {30'd0, mem_req, mem_we}, 32'h2);
        chk(mem_addr == 16'h1000, "R1 first fetch address", {16'd0, mem_addr}, 32'h1000);
        chk(halted == 1'b0, "R1 halted low", {31'd0, halted}, 32'd0);
        chk(cpu_status == 8'h00, "R1 status clear", {24'd0, cpu_status}, 32'd0);
        chk(alu_x == 16'd0 && alu_y == 16'd0, "R1 X Y clear", {alu_x, alu_y}, 32'd0);

        // ---- R2 R4 R5: DWR / WTM / SRA swept over values and latencies ----
        for (int l = 0; l < 4; l++) begin
            for (int k = 0; k < 4; k++) begin
                lat = l;
                start_prog();
                emit(16'h0014); emit(vals[k]);
                emit(16'h0002); emit(16'h2000);
                emit(16'h0003); emit(16'h0001);
                emit(16'h0014); emit(~vals[k]);
                emit(16'h0002); emit(16'h2002);
                emit(16'h000E);
                run();
                chk(rd(16'h2000) == vals[k][15:8], "R4 WTM high byte at A", {24'd0, rd(16'h2000)}, {24'd0, vals[k][15:8]});
                chk(rd(16'h2001) == vals[k][7:0], "R4 WTM low byte at A+1", {24'd0, rd(16'h2001)}, {24'd0, vals[k][7:0]});
                chk(rdw(16'h2002) == ~vals[k], "R5 DWR into Y after SRA", {16'd0, rdw(16'h2002)}, {16'd0, ~vals[k]});
                chk(alu_x == vals[k] && alu_y == ~vals[k], "R5 register contents", {alu_x, alu_y}, {vals[k], ~vals[k]});
                chk(cpu_status == 8'h0A, "R9 status halt and select", {24'd0, cpu_status}, 32'h0A);
            end
        end

        // ---- R9: stays halted with no requests ----
        begin
            logic quiet;
            quiet = 1'b1;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk); #1;
                if (mem_req || !halted) quiet = 1'b0;
            end
            chk(quiet, "R9 no request after halt", {31'd0, quiet}, 32'd1);
        end

        // ---- R4 R12: LFM, ALU add, compare ----
        for (int k = 0; k < 4; k++) begin
            logic [15:0] s;
            logic [15:0] c;
            s = pa[k] + pb[k];
            c = (k % 2 == 0) ? pa[k] : ~pa[k];
            lat = k;
            start_prog();
            put(16'h3000, pa[k]);
            put(16'h3002, pb[k]);
            emit(16'h0001); emit(16'h3000);
            emit(16'h0003); emit(16'h0001);
            emit(16'h0001); emit(16'h3002);
            emit(16'h0004);
            emit(16'h0002); emit(16'h2004);
            emit(16'h0003); emit(16'h0000);
            emit(16'h0014); emit(c);
            emit(16'h0008);
            emit(16'h000E);
            run();
            chk(rdw(16'h2004) == s, "R12 ALU sum into accumulator", {16'd0, rdw(16'h2004)}, {16'd0, s});
            chk(alu_y == s, "R4 LFM then add in Y", {16'd0, alu_y}, {16'd0, s});
            chk(cpu_status == (8'h08 | {7'd0, c == s}), "R12 compare writes equality bit",
                {24'd0, cpu_status}, {24'd0, 8'h08 | {7'd0, c == s}});
        end

        // ---- R10: CLR returns selection to X ----
        lat = 1;
        start_prog();
        emit(16'h0003); emit(16'h0001);
        emit(16'h0008);
        emit(16'h000D);
        emit(16'h0014); emit(16'h0042);
        emit(16'h000E);
        run();
        chk(alu_x == 16'h0042 && alu_y == 16'h0000, "R10 CLR selects X", {alu_x, alu_y}, 32'h00420000);
        chk(cpu_status == 8'h08, "R10 CLR zeroes equality and select", {24'd0, cpu_status}, 32'h08);

        // ---- R7: jumps taken and not taken ----
        for (int l = 0; l < 3; l++) begin
            lat = l;
            start_prog();
            emit(16'h0014); emit(16'h0000);
            emit(16'h000A); emit(16'h1010);
            emit(16'h0014); emit(16'h1111);
            emit(16'h000E);
            ptr = 16'h1010;
            emit(16'h000B); emit(16'h1000);
            emit(16'h0014); emit(16'h0005);
            emit(16'h000B); emit(16'h1024);
            emit(16'h0002); emit(16'h2010);
            emit(16'h000E);
            ptr = 16'h1024;
            emit(16'h000A); emit(16'h1000);
            emit(16'h000C); emit(16'h1030);
            emit(16'h000E);
            ptr = 16'h1030;
            emit(16'h0002); emit(16'h2010);
            emit(16'h000E);
            run();
            chk(rdw(16'h2010) == 16'h0005, "R7 jump path store", {16'd0, rdw(16'h2010)}, 32'h0005);
            chk(alu_x == 16'h0005, "R7 skipped DWR not executed", {16'd0, alu_x}, 32'h0005);
        end

        // ---- R6 R8 R11: indirect access, ROM stores, NOP-like opcodes ----
        for (int l = 0; l < 4; l++) begin
            lat = l;
            start_prog();
            put(16'h3000, 16'hCAFE);
            put(16'h0800, 16'hAA55);
            mem[16'h0FFF] = 8'h77;
            emit(16'h0014); emit(16'h3000);
            emit(16'h0015);
            emit(16'hC000);
            emit(16'h00FF);
            emit(16'h0000);
            emit(16'h0003); emit(16'h0001);
            emit(16'h0014); emit(16'h2100);
            emit(16'h0003); emit(16'h0000);
            emit(16'h0016);
            emit(16'h0002); emit(16'h0800);
            emit(16'h0002); emit(16'h0FFF);
            emit(16'h000E);
            run();
            chk(alu_x == 16'hCAFE, "R6 ILM through accumulator address", {16'd0, alu_x}, 32'hCAFE);
            chk(rdw(16'h2100) == 16'hCAFE, "R6 IWR to other register address", {16'd0, rdw(16'h2100)}, 32'hCAFE);
            chk(alu_y == 16'h2100 && cpu_status == 8'h08, "R11 reserved and undefined act as NOP",
                {alu_y, 8'd0, cpu_status}, 32'h21000008);
            chk(rdw(16'h0800) == 16'hAA55 && rom_wr == 0, "R8 ROM store ignored",
                {rdw(16'h0800), rom_wr[15:0]}, 32'hAA550000);
            chk(rd(16'h0FFF) == 8'h77 && rd(16'h1000) == 8'hFE, "R8 straddling store writes only low byte",
                {16'd0, rd(16'h0FFF), rd(16'h1000)}, 32'h77FE);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule